// File: doc/BRIEF.md
# Operand Select and Write-Back Register Unit

This unit supplies the two source operands of a small load-store processor core and accepts its one result. A 4-bit selector names an operand. The low selector values are fixed sources: two constants, the data-memory read wire, the instruction immediate and the fetch program counter. Two selector values name the core's data-address and jump-target registers, which this unit holds. The values above those name a bank of general-purpose registers.

The two read ports are purely combinational. Each one decodes its selector independently. The single write port updates a stored register on the rising clock edge when the write enable is high. Writes aimed at a fixed source, or at a selector past the last general-purpose register, leave every stored register unchanged.

The data-address and jump-target registers also drive dedicated outputs, so the core can present them to the memories without spending a read port. The data width `W` and the register count `NGPR` are parameters. The design assumes `W >= 8` and `1 <= NGPR <= 9`.

Top module: `operand_regfile`

## Requirements
- R1: Selector 0 reads as all zeros and selector 1 reads as the value one, on either read port.
- R2: Selector 2 reads the current `mem_rdata` input combinationally.
- R3: Selector 3 reads the 8-bit `imm` input, zero-extended to W bits. Bits [7:4] of `imm` come from the instruction's second-source field and bits [3:0] from its first-source field.
- R4: Selector 4 is the data-address register. It is readable and writable, and its value is always present on `maddr`.
- R5: Selector 5 is the jump-target register. It is readable and writable, and its value is always present on `jaddr`.
- R6: Selector 6 reads the current `pc_next` input combinationally.
- R7: Selector 7+k reads general-purpose register k, for k from 0 to NGPR-1. A write to 7+k updates that register.
- R8: A write to selector 0, 1, 2, 3 or 6, or to any selector of 7+NGPR or above, changes no stored register.
- R9: A read of a selector of 7+NGPR or above returns zero.
- R10: A write takes effect at the rising edge where `wr_en` is high. During that cycle the read ports still show the old value. With `wr_en` low, no stored register changes.
- R11: A clock edge with `rst_n` low clears the data-address register, the jump-target register and all general-purpose registers to zero.
- R12: The two read ports decode independently, so different selectors return their own values in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_a | input | 4 | Selector for read port A |
| sel_b | input | 4 | Selector for read port B |
| wr_en | input | 1 | Write enable for the write port |
| wr_sel | input | 4 | Selector for the write port |
| wr_data | input | W | Data to write |
| mem_rdata | input | W | Data-memory read data, readable at selector 2 |
| imm | input | 8 | Instruction immediate, readable at selector 3 |
| pc_next | input | W | Program counter value, readable at selector 6 |
| rd_a | output | W | Read port A data |
| rd_b | output | W | Read port B data |
| maddr | output | W | Data-address register value |
| jaddr | output | W | Jump-target register value |

## Verification
Read results depend only on the current selectors and inputs, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and compares both read ports shortly before the next rising edge. A write becomes visible one rising edge later, on the read ports and on `maddr` or `jaddr`. The bench's reference model applies each write only at the rising edge. The comparison in the write cycle itself therefore expects the old value, and the comparison in the following cycle expects the new one.

// File: rtl/opsel_pkg.sv
// Package: opsel_pkg
// Purpose: selector encodings shared by the operand register unit and its parts.
// Assumes: 4-bit selectors; general-purpose registers start at SEL_GPR0.
package opsel_pkg;
    localparam int SELW = 4;
    localparam logic [SELW-1:0] SEL_ZERO  = 4'd0;
    localparam logic [SELW-1:0] SEL_ONE   = 4'd1;
    localparam logic [SELW-1:0] SEL_MDATA = 4'd2;
    localparam logic [SELW-1:0] SEL_IMM   = 4'd3;
    localparam logic [SELW-1:0] SEL_MADDR = 4'd4;
    localparam logic [SELW-1:0] SEL_JADDR = 4'd5;
    localparam logic [SELW-1:0] SEL_PC    = 4'd6;
    localparam int              SEL_GPR0  = 7;
endpackage

// File: rtl/opsel_wdecode.sv
// Module: opsel_wdecode
// Purpose: turns the write enable and write selector into one enable per stored register.
// Assumes: NGPR general-purpose registers mapped from SEL_GPR0 upward. Any selector with no
//          stored register behind it raises no enable.
module opsel_wdecode
    import opsel_pkg::*;
#(
    parameter int NGPR = 8
) (
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_sel,
    output logic            we_maddr,
    output logic            we_jaddr,
    output logic [NGPR-1:0] we_gpr
);
    // Enables for the two special registers.
    always_comb begin
        we_maddr = wr_en && (wr_sel == SEL_MADDR);
        we_jaddr = wr_en && (wr_sel == SEL_JADDR);
    end

    // One enable per general-purpose register.
    for (genvar k = 0; k < NGPR; k++) begin : g_we
        assign we_gpr[k] = wr_en && (wr_sel == SELW'(SEL_GPR0 + k));
    end
endmodule

// File: rtl/opsel_store.sv
// Module: opsel_store
// Purpose: holds the data-address register, the jump-target register and the
//          general-purpose register bank.
// Assumes: at most one write enable is high per cycle (the decoder guarantees this);
//          synchronous active-low reset clears all state.
module opsel_store #(
    parameter int W    = 16,
    parameter int NGPR = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_maddr,
    input  logic                we_jaddr,
    input  logic [NGPR-1:0]     we_gpr,
    input  logic [W-1:0]        wr_data,
    output logic [W-1:0]        maddr_q,
    output logic [W-1:0]        jaddr_q,
    output logic [NGPR-1:0][W-1:0] gpr_q
);
    // Data-address register.
    always_ff @(posedge clk) begin
        if (!rst_n)        maddr_q <= '0;
        else if (we_maddr) maddr_q <= wr_data;
    end

    // Jump-target register.
    always_ff @(posedge clk) begin
        if (!rst_n)        jaddr_q <= '0;
        else if (we_jaddr) jaddr_q <= wr_data;
    end

    // General-purpose register bank, one register per generate slot.
    for (genvar k = 0; k < NGPR; k++) begin : g_gpr
        always_ff @(posedge clk) begin
            if (!rst_n)         gpr_q[k] <= '0;
            else if (we_gpr[k]) gpr_q[k] <= wr_data;
        end
    end

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (maddr_q == '0 && jaddr_q == '0));
endmodule

// File: rtl/opsel_rdmux.sv
// Module: opsel_rdmux
// Purpose: one combinational read port that maps a selector to a constant, an input wire,
//          a special register or a general-purpose register.
// Assumes: W >= 8 so the immediate fits; unmapped selectors read as zero.
module opsel_rdmux
    import opsel_pkg::*;
#(
    parameter int W    = 16,
    parameter int NGPR = 8
) (
    input  logic [SELW-1:0]        sel,
    input  logic [W-1:0]           mem_rdata,
    input  logic [7:0]             imm,
    input  logic [W-1:0]           pc_next,
    input  logic [W-1:0]           maddr_q,
    input  logic [W-1:0]           jaddr_q,
    input  logic [NGPR-1:0][W-1:0] gpr_q,
    output logic [W-1:0]           rdata
);
    // Fixed sources first, then the register bank; anything else reads zero.
    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_ZERO:  rdata = '0;
            SEL_ONE:   rdata = W'(1);
            SEL_MDATA: rdata = mem_rdata;
            SEL_IMM:   rdata = W'(imm);
            SEL_MADDR: rdata = maddr_q;
            SEL_JADDR: rdata = jaddr_q;
            SEL_PC:    rdata = pc_next;
            default: begin
                for (int k = 0; k < NGPR; k++) begin
                    if (sel == SELW'(SEL_GPR0 + k)) rdata = gpr_q[k];
                end
            end
        endcase
    end
endmodule

// File: rtl/operand_regfile.sv
// Module: operand_regfile
// Purpose: operand selection and write-back unit. It has two combinational read ports,
//          one clocked write port, and the data-address and jump-target registers exported.
// Assumes: W >= 8, 1 <= NGPR <= 9 (the bank must fit in the 4-bit selector space);
//          synchronous active-low reset.
module operand_regfile
    import opsel_pkg::*;
#(
    parameter int W    = 16,
    parameter int NGPR = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   sel_a,
    input  logic [3:0]   sel_b,
    input  logic         wr_en,
    input  logic [3:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] mem_rdata,
    input  logic [7:0]   imm,
    input  logic [W-1:0] pc_next,
    output logic [W-1:0] rd_a,
    output logic [W-1:0] rd_b,
    output logic [W-1:0] maddr,
    output logic [W-1:0] jaddr
);
    localparam int NPORTS = 2;

    logic                we_maddr;
    logic                we_jaddr;
    logic [NGPR-1:0]     we_gpr;
    logic [W-1:0]        maddr_q;
    logic [W-1:0]        jaddr_q;
    logic [NGPR-1:0][W-1:0] gpr_q;
    logic [NPORTS-1:0][SELW-1:0] port_sel;
    logic [NPORTS-1:0][W-1:0]    port_data;

    opsel_wdecode #(.NGPR(NGPR)) u_wdecode (
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .we_maddr (we_maddr),
        .we_jaddr (we_jaddr),
        .we_gpr   (we_gpr)
    );

    opsel_store #(.W(W), .NGPR(NGPR)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_maddr (we_maddr),
        .we_jaddr (we_jaddr),
        .we_gpr   (we_gpr),
        .wr_data  (wr_data),
        .maddr_q  (maddr_q),
        .jaddr_q  (jaddr_q),
        .gpr_q    (gpr_q)
    );

    // Gather the port selectors so the read ports can be generated.
    always_comb begin
        port_sel[0] = sel_a;
        port_sel[1] = sel_b;
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        opsel_rdmux #(.W(W), .NGPR(NGPR)) u_rdmux (
            .sel       (port_sel[p]),
            .mem_rdata (mem_rdata),
            .imm       (imm),
            .pc_next   (pc_next),
            .maddr_q   (maddr_q),
            .jaddr_q   (jaddr_q),
            .gpr_q     (gpr_q),
            .rdata     (port_data[p])
        );
    end

    // Drive the outputs.
    always_comb begin
        rd_a  = port_data[0];
        rd_b  = port_data[1];
        maddr = maddr_q;
        jaddr = jaddr_q;
    end

    // R4
    maddr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_MADDR) |=> (maddr == $past(wr_data)));

    // R5
    jaddr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_JADDR) |=> (jaddr == $past(wr_data)));

    // R8
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel <= SEL_IMM || wr_sel == SEL_PC ||
                   wr_sel >= SELW'(SEL_GPR0 + NGPR)))
        |=> ($stable(maddr) && $stable(jaddr)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(maddr) && $stable(jaddr)));

    // R6
    pc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b == SEL_PC) |-> (rd_b == pc_next));

    // R7
    gpr0_roundtrip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SELW'(SEL_GPR0)) ##1 (sel_a == SELW'(SEL_GPR0))
        |-> (rd_a == $past(wr_data)));
endmodule

// File: tb/operand_regfile_tb.sv
module operand_regfile_tb;
    localparam int W    = 16;
    localparam int NGPR = 8;
    localparam int BASE = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   sel_a = '0, sel_b = '0, wr_sel = '0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0, mem_rdata = '0, pc_next = '0;
    logic [7:0]   imm = '0;
    logic [W-1:0] rd_a, rd_b, maddr, jaddr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference state.
    logic [W-1:0] m_ar, m_jr;
    logic [W-1:0] m_gpr [NGPR];

    always #10 clk = ~clk;

    operand_regfile #(.W(W), .NGPR(NGPR)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .mem_rdata(mem_rdata), .imm(imm), .pc_next(pc_next),
        .rd_a(rd_a), .rd_b(rd_b), .maddr(maddr), .jaddr(jaddr)
    );

    function automatic logic [W-1:0] expect_read(input int s);
        if (s == 0) return '0;
        if (s == 1) return W'(1);
        if (s == 2) return mem_rdata;
        if (s == 3) return {{(W-8){1'b0}}, imm};
        if (s == 4) return m_ar;
        if (s == 5) return m_jr;
        if (s == 6) return pc_next;
        if (s >= BASE && s < BASE + NGPR) return m_gpr[s - BASE];
        return '0;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive just after the falling edge, compare before the rising edge,
    // then apply the write to the model at the rising edge.
    task automatic cycle(input string tag, input int sa, input int sb,
                         input bit we, input int ws, input logic [W-1:0] wd);
        sel_a = 4'(sa); sel_b = 4'(sb);
        wr_en = we; wr_sel = 4'(ws); wr_data = wd;
        #8;
        check(tag, "rd_a", rd_a, expect_read(sa));
        check(tag, "rd_b", rd_b, expect_read(sb));
        check(tag, "maddr", maddr, m_ar);
        check(tag, "jaddr", jaddr, m_jr);
        @(posedge clk);
        if (!rst_n) begin
            m_ar = '0; m_jr = '0;
            for (int k = 0; k < NGPR; k++) m_gpr[k] = '0;
        end else if (we) begin
            if (ws == 4) m_ar = wd;
            else if (ws == 5) m_jr = wd;
            else if (ws >= BASE && ws < BASE + NGPR) m_gpr[ws - BASE] = wd;
        end
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_ar = 'x; m_jr = 'x;
        for (int k = 0; k < NGPR; k++) m_gpr[k] = 'x;
        @(negedge clk);
        // R11: reset clears; reads are not compared while state is unknown.
        rst_n = 1'b0;
        @(posedge clk); @(posedge clk);
        m_ar = '0; m_jr = '0;
        for (int k = 0; k < NGPR; k++) m_gpr[k] = '0;
        @(negedge clk);
        rst_n = 1'b1;
        cycle("R11", 4, 5, 0, 0, '0);
        cycle("R11", BASE, BASE + NGPR - 1, 0, 0, '0);

        // R1 constants.
        cycle("R1", 0, 1, 0, 0, '0);
        cycle("R1", 1, 0, 0, 0, '0);
        // R2 and R3 together on separate ports (R12).
        mem_rdata = 16'hA5C3; imm = 8'hC3;
        cycle("R12", 2, 3, 0, 0, '0);
        mem_rdata = 16'h0F0F; imm = 8'h7E;
        cycle("R2", 2, 2, 0, 0, '0);
        cycle("R3", 3, 0, 0, 0, '0);
        // R6 program counter.
        pc_next = 16'h0123;
        cycle("R6", 6, 6, 0, 0, '0);

        // R4 / R10: write the data-address register, old value seen during the write.
        cycle("R10", 4, 4, 1, 4, 16'h1234);
        cycle("R4", 4, 0, 0, 0, '0);
        // R5 jump-target register.
        cycle("R10", 5, 5, 1, 5, 16'hBEEF);
        cycle("R5", 5, 4, 0, 0, '0);

        // R7: fill and read each general-purpose register.
        for (int k = 0; k < NGPR; k++)
            cycle("R7", BASE + k, 4, 1, BASE + k, W'(16'h1000 + k * 16'h0111));
        for (int k = 0; k < NGPR; k++)
            cycle("R7", BASE + k, BASE + NGPR - 1 - k, 0, 0, '0);

        // R8: writes to fixed sources and past the bank, then read every store back.
        cycle("R8", 4, 5, 1, 0, 16'hFFFF);
        cycle("R8", 4, 5, 1, 1, 16'hFFFF);
        cycle("R8", 4, 5, 1, 2, 16'hFFFF);
        cycle("R8", 4, 5, 1, 3, 16'hFFFF);
        cycle("R8", 4, 5, 1, 6, 16'hFFFF);
        for (int s = BASE + NGPR; s < 16; s++) cycle("R8", 4, 5, 1, s, 16'hFFFF);
        for (int k = 0; k < NGPR; k++) cycle("R8", BASE + k, 0, 0, 0, '0);

        // R9: unmapped selectors read zero.
        for (int s = BASE + NGPR; s < 16; s++) cycle("R9", s, s, 0, 0, '0);

        // R10: enable low leaves state alone.
        cycle("R10", 4, BASE, 0, 4, 16'h5555);
        cycle("R10", 4, BASE, 0, BASE, 16'h5555);
        cycle("R10", 4, BASE, 0, 0, '0);

        // Mixed traffic against the model.
        for (int i = 0; i < 400; i++) begin
            mem_rdata = W'($urandom); imm = 8'($urandom); pc_next = W'($urandom);
            cycle("R10", int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                  1'($urandom), int'($urandom_range(0, 15)), W'($urandom));
        end

        // R11: reset in mid-run clears everything.
        rst_n = 1'b0;
        cycle("R11", 0, 0, 1, 4, 16'h7777);
        rst_n = 1'b1;
        cycle("R11", 4, 5, 0, 0, '0);
        for (int k = 0; k < NGPR; k++) cycle("R11", BASE + k, 0, 0, 0, '0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule